// File: doc/BRIEF.md
# Fast Monitoring Status Encoder

This block condenses a board's health into four status wires for a fast-monitoring network: ready, busy, warning-overflow and out-of-sync. It has no fifth wire for error. An error is shown by driving ready and busy high together. Every output is registered. A status reader therefore sees a change one clock after the condition that causes it, or two clocks for warning-overflow.

Readiness is the AND of a set of prerequisites, and that set depends on the last start-up kind. A start-up kind is latched on a `start_stb` pulse, and reset selects the power-on kind.

| Start-up kind | Code | Required prerequisites |
|---|---|---|
| Power-on | 0 or 3 | all five |
| Hard reset | 1 | all except table-loaded |
| Level-1 reset | 2 | link alignment and pipeline-filled only |

Warning-overflow follows a backlog counter. The counter goes up on each accepted trigger and down on each event sent. It saturates at zero and at its maximum. The flag uses hysteresis between a high mark and a low mark. All inputs are plain synchronous levels or single-cycle pulses, so there is no back-pressure anywhere in the block.

Top module: `fm_status_enc`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, the outputs are rdy=0, bsy=1, wof=0 and osy=0. Reset also selects the power-on start-up kind.
- R2: After power-on (kind code 0 or 3), rdy=1 and bsy=0 only when cfg_done, sw_ready, tables_loaded, align_done and pipe_filled are all 1. Otherwise rdy=0 and bsy=1. The outputs follow the inputs one cycle later.
- R3: After a hard reset (kind code 1), tables_loaded has no effect on readiness. The other four prerequisites are still required.
- R4: After a level-1 reset (kind code 2), only align_done and pipe_filled are required. cfg_done, sw_ready and tables_loaded have no effect.
- R5: A new kind code is latched on the edge where start_stb is 1. The readiness rule for that kind applies to the outputs one cycle after the latch.
- R6: If any bit of link_sd is 0, the next cycle shows rdy=1 and bsy=1, whatever the readiness prerequisites are.
- R7: fm_osy is 1 one cycle after any bit of link_osy is 1 or main_osy is 1. Otherwise it is 0.
- R8: The backlog counter adds 1 for each cycle with trig_acc=1 and subtracts 1 for each cycle with evt_sent=1. If both are 1 in the same cycle, the count does not change. The count never wraps below 0 or above its maximum.
- R9: fm_wof becomes 1 on the cycle after the backlog is at or above wof_hi. It becomes 0 on the cycle after the backlog is below wof_lo. Between the two marks it keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_stb | input | 1 | Latches start_kind |
| start_kind | input | 2 | 0 power-on, 1 hard reset, 2 level-1 reset, 3 treated as power-on |
| cfg_done | input | 1 | Device configuration complete |
| sw_ready | input | 1 | Software has set the ready flag |
| tables_loaded | input | 1 | Lookup tables loaded |
| align_done | input | 1 | Input alignment done and data flowing |
| pipe_filled | input | 1 | Data has reached the pipeline output |
| link_sd | input | NUM_LINKS | Per-link signal detect |
| link_osy | input | NUM_LINKS | Per-link out-of-sync |
| main_osy | input | 1 | Central out-of-sync |
| trig_acc | input | 1 | Trigger accepted pulse |
| evt_sent | input | 1 | Event transmitted pulse |
| wof_hi | input | CNT_W | Backlog level that sets warning |
| wof_lo | input | CNT_W | Backlog level below which warning clears |
| fm_rdy | output | 1 | Ready line |
| fm_bsy | output | 1 | Busy line |
| fm_wof | output | 1 | Warning-overflow line |
| fm_osy | output | 1 | Out-of-sync line |

## Verification
A start-up kind latched wrongly changes which prerequisites matter. The fault appears at rdy/bsy two cycles after the start_stb pulse, when one prerequisite is dropped that should or should not be masked. A backlog counter that drifts, wraps or mishandles simultaneous pulses shows up as fm_wof asserting one trigger early or late, or failing to clear at the low mark. The hysteresis sequence and the underflow probe expose this within a few cycles. A fault in the error priority or in the out-of-sync OR is visible at the next edge.

// File: rtl/fm_pkg.sv
package fm_pkg;
  typedef enum logic [1:0] {
    KIND_POWER = 2'd0,
    KIND_HARD  = 2'd1,
    KIND_L1    = 2'd2,
    KIND_ALT   = 2'd3
  } start_kind_e;
endpackage

// File: rtl/fm_ready_eval.sv
module fm_ready_eval
  import fm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_stb,
  input  logic [1:0] start_kind,
  input  logic       cfg_done,
  input  logic       sw_ready,
  input  logic       tables_loaded,
  input  logic       align_done,
  input  logic       pipe_filled,
  output logic       ready
);
  start_kind_e kind_q;
  logic need_cfg, need_tab;

  always_ff @(posedge clk) begin
    if (!rst_n)         kind_q <= KIND_POWER;
    else if (start_stb) kind_q <= start_kind_e'(start_kind);
  end

  always_comb begin
    need_cfg = 1'b1;
    need_tab = 1'b1;
    case (kind_q)
      KIND_HARD: begin need_cfg = 1'b1; need_tab = 1'b0; end
      KIND_L1:   begin need_cfg = 1'b0; need_tab = 1'b0; end
      default:   begin need_cfg = 1'b1; need_tab = 1'b1; end
    endcase
  end

  assign ready = align_done && pipe_filled
              && (!need_cfg || (cfg_done && sw_ready))
              && (!need_tab || tables_loaded);

  AST_L1_MINIMAL: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == KIND_L1 && align_done && pipe_filled) |-> ready); // R4
endmodule

// File: rtl/fm_backlog.sv
module fm_backlog #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_acc,
  input  logic             evt_sent,
  input  logic [CNT_W-1:0] wof_hi,
  input  logic [CNT_W-1:0] wof_lo,
  output logic             wof
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (trig_acc && !evt_sent && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    else if (evt_sent && !trig_acc && cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               wof <= 1'b0;
    else if (cnt_q >= wof_hi) wof <= 1'b1;
    else if (cnt_q < wof_lo)  wof <= 1'b0;
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && evt_sent && !trig_acc) |=> cnt_q == '0); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && trig_acc && !evt_sent) |=> cnt_q == CNT_MAX); // R8
  AST_WOF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q >= wof_hi) |=> wof); // R9
endmodule

// File: rtl/fm_status_enc.sv
module fm_status_enc #(
  parameter int NUM_LINKS = 5,
  parameter int CNT_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_stb,
  input  logic [1:0]           start_kind,
  input  logic                 cfg_done,
  input  logic                 sw_ready,
  input  logic                 tables_loaded,
  input  logic                 align_done,
  input  logic                 pipe_filled,
  input  logic [NUM_LINKS-1:0] link_sd,
  input  logic [NUM_LINKS-1:0] link_osy,
  input  logic                 main_osy,
  input  logic                 trig_acc,
  input  logic                 evt_sent,
  input  logic [CNT_W-1:0]     wof_hi,
  input  logic [CNT_W-1:0]     wof_lo,
  output logic                 fm_rdy,
  output logic                 fm_bsy,
  output logic                 fm_wof,
  output logic                 fm_osy
);
  logic ready, link_err;

  fm_ready_eval u_ready (
    .clk(clk), .rst_n(rst_n), .start_stb(start_stb), .start_kind(start_kind),
    .cfg_done(cfg_done), .sw_ready(sw_ready), .tables_loaded(tables_loaded),
    .align_done(align_done), .pipe_filled(pipe_filled), .ready(ready)
  );

  fm_backlog #(.CNT_W(CNT_W)) u_backlog (
    .clk(clk), .rst_n(rst_n), .trig_acc(trig_acc), .evt_sent(evt_sent),
    .wof_hi(wof_hi), .wof_lo(wof_lo), .wof(fm_wof)
  );

  assign link_err = !(&link_sd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fm_rdy <= 1'b0;
      fm_bsy <= 1'b1;
      fm_osy <= 1'b0;
    end else begin
      fm_rdy <= link_err || ready;
      fm_bsy <= link_err || !ready;
      fm_osy <= (|link_osy) || main_osy;
    end
  end

  AST_ERR_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    link_err |=> (fm_rdy && fm_bsy)); // R6
  AST_NOERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !link_err |=> (fm_rdy != fm_bsy)); // R2
  AST_OSY_OR: assert property (@(posedge clk) disable iff (!rst_n)
    ((|link_osy) || main_osy) |=> fm_osy); // R7
endmodule

// File: tb/fm_status_enc_test.sv
module fm_status_enc_test;
  localparam int NL = 5;
  localparam int CW = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_stb = 1'b0;
  logic [1:0] start_kind = 2'd0;
  logic cfg_done = 1'b0, sw_ready = 1'b0, tables_loaded = 1'b0;
  logic align_done = 1'b0, pipe_filled = 1'b0;
  logic [NL-1:0] link_sd = '1, link_osy = '0;
  logic main_osy = 1'b0, trig_acc = 1'b0, evt_sent = 1'b0;
  logic [CW-1:0] wof_hi = 8'd4, wof_lo = 8'd2;
  logic fm_rdy, fm_bsy, fm_wof, fm_osy;
  int n_run = 0, n_fail = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  fm_status_enc #(.NUM_LINKS(NL), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .start_stb(start_stb), .start_kind(start_kind),
    .cfg_done(cfg_done), .sw_ready(sw_ready), .tables_loaded(tables_loaded),
    .align_done(align_done), .pipe_filled(pipe_filled), .link_sd(link_sd),
    .link_osy(link_osy), .main_osy(main_osy), .trig_acc(trig_acc),
    .evt_sent(evt_sent), .wof_hi(wof_hi), .wof_lo(wof_lo),
    .fm_rdy(fm_rdy), .fm_bsy(fm_bsy), .fm_wof(fm_wof), .fm_osy(fm_osy)
  );

  // {kind[1:0], cfg, flag, tab, align, pipe, sd_all, exp_rdy, exp_bsy}
  localparam int NV = 11;
  localparam logic [9:0] VEC [NV] = '{
    10'b00_11111_1_10, // R2 power-on all present
    10'b00_11011_1_01, // R2 power-on, tables missing
    10'b00_01111_1_01, // R2 power-on, cfg missing
    10'b01_11011_1_10, // R3 hard, tables ignored
    10'b01_01111_1_01, // R3 hard, cfg needed
    10'b01_10111_1_01, // R3 hard, flag needed
    10'b10_00011_1_10, // R4 level-1, only align+pipe
    10'b10_00001_1_01, // R4 level-1, align needed
    10'b10_11110_1_01, // R4 level-1, pipe needed
    10'b11_11011_1_01, // R2 code 3 as power-on
    10'b00_00000_0_11  // R6 error overrides not-ready
  };

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic pulse_trig(input int n);
    for (int i = 0; i < n; i++) begin trig_acc = 1'b1; step(); end
    trig_acc = 1'b0;
  endtask

  task automatic pulse_sent(input int n);
    for (int i = 0; i < n; i++) begin evt_sent = 1'b1; step(); end
    evt_sent = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    step(); step();
    chk("R1 rdy", fm_rdy, 1'b0); chk("R1 bsy", fm_bsy, 1'b1);
    chk("R1 wof", fm_wof, 1'b0); chk("R1 osy", fm_osy, 1'b0);
    rst_n = 1'b1;
    step();
    chk("R1 bsy after release", fm_bsy, 1'b1);

    for (int v = 0; v < NV; v++) begin
      start_kind = VEC[v][9:8];
      start_stb = 1'b1;
      {cfg_done, sw_ready, tables_loaded, align_done, pipe_filled} = VEC[v][7:3];
      link_sd = VEC[v][2] ? '1 : 5'b11011;
      step();
      start_stb = 1'b0;
      step();
      chk($sformatf("R5 vec%0d rdy", v), fm_rdy, VEC[v][1]);
      chk($sformatf("R5 vec%0d bsy", v), fm_bsy, VEC[v][0]);
    end

    // R5: strobe low does not change kind (currently power-on from last vector)
    link_sd = '1;
    start_kind = 2'd2;
    {cfg_done, sw_ready, tables_loaded, align_done, pipe_filled} = 5'b00011;
    step(); step();
    chk("R5 no strobe keeps kind", fm_rdy, 1'b0);

    // R6 single link drop while ready
    {cfg_done, sw_ready, tables_loaded, align_done, pipe_filled} = 5'b11111;
    link_sd = 5'b01111;
    step();
    chk("R6 rdy", fm_rdy, 1'b1); chk("R6 bsy", fm_bsy, 1'b1);
    link_sd = '1;
    step();
    chk("R6 cleared bsy", fm_bsy, 1'b0);

    // R7
    link_osy = 5'b00100; step(); chk("R7 link osy", fm_osy, 1'b1);
    link_osy = '0;       step(); chk("R7 clear", fm_osy, 1'b0);
    main_osy = 1'b1;     step(); chk("R7 main osy", fm_osy, 1'b1);
    main_osy = 1'b0;     step(); chk("R7 clear2", fm_osy, 1'b0);

    // R8 underflow: sends at zero must not wrap
    pulse_sent(2);
    pulse_trig(3); step();
    chk("R8 no underflow", fm_wof, 1'b0);
    trig_acc = 1'b1; evt_sent = 1'b1; step();
    trig_acc = 1'b0; evt_sent = 1'b0; step();
    chk("R8 simultaneous no change", fm_wof, 1'b0);
    // R9 hysteresis
    pulse_trig(1); step();
    chk("R9 set at high mark", fm_wof, 1'b1);
    pulse_sent(1); step(); chk("R9 hold at 3", fm_wof, 1'b1);
    pulse_sent(1); step(); chk("R9 hold at low mark", fm_wof, 1'b1);
    pulse_sent(1); step(); chk("R9 clear below low", fm_wof, 1'b0);
    pulse_trig(1); step(); chk("R9 no set at 2", fm_wof, 1'b0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule